// File: doc/BRIEF.md
# Interrupt CPU Interface Acknowledge Unit

This block is the per-core end of an interrupt controller. A distributor offers it one candidate interrupt at a time, carrying an identifier, an 8-bit priority, a group bit and the number of the core that raised it. The unit decides whether that candidate may be signalled to its core and drives either a normal interrupt line or a fast interrupt line. Software sees four 32-bit registers on a simple single-cycle register bus: control, priority mask, acknowledge and completion.

Reading the acknowledge register takes the signalled interrupt: the read returns the identifier with the source core number packed above it. In the same cycle the unit tells the distributor to clear that interrupt's pending state and records it as active. Until software writes the same value to the completion register, nothing further is signalled. Preemption, priority grouping and virtualization are not part of this block.

The sequencing is a three-state machine. `S_IDLE` (nothing signalled, nothing active) moves to `S_SIGNAL` when a candidate qualifies. `S_SIGNAL` returns to `S_IDLE` if the candidate stops qualifying, or moves to `S_ACTIVE` on an acknowledge read (the "take" transition). `S_ACTIVE` returns to `S_IDLE` on a matching completion write and stays put on any other.

Top module: `irq_cpu_iface`

## Requirements
- R1: The control register is at offset 0x000 and keeps bits 0, 1 and 3 (all other bits read 0); the priority mask is at offset 0x004 and keeps 8 bits; both reset to 0.
- R2: A group 0 candidate is signalled only while control bit 0 is set, and a group 1 candidate only while control bit 1 is set.
- R3: With control bit 3 set, group 0 is signalled on `fiq_o`; otherwise, and always for group 1, it is signalled on `irq_o`. The two lines are never high together.
- R4: A candidate is signalled only when its priority is numerically strictly below the priority mask; a priority equal to the mask is held back.
- R5: A read at offset 0x00C while an interrupt is signalled and still qualifying returns the identifier in bits 9:0, the source core in bits 12:10 and zero above. In that same cycle it pulses `clr_pend_o` with `clr_id_o` equal to the identifier, and the interrupt becomes active.
- R6: A read at 0x00C returns the spurious value 1023 (0x3FF) when nothing is signalled or qualifying, when signalling is off, or when an interrupt is already active.
- R7: The output line rises on the clock edge after a candidate first qualifies. Both lines are low from the edge that ends an acknowledge read until the interrupt completes and a candidate qualifies again.
- R8: A write to offset 0x010 whose bits 12:0 equal the value returned by the acknowledge read completes the active interrupt; a write with a different identifier or core number is ignored and the interrupt stays active.
- R9: Writing 0 to the control register stops all signalling (lines low one edge after the register changes); writing the former value back restores it.
- R10: After completion the unit passes through `S_IDLE`, so a candidate still present is signalled again on the second edge after the completion write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate identifier |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_grp | input | 1 | Candidate group (0 or 1) |
| cand_src | input | 3 | Core that raised the candidate |
| clr_pend_o | output | 1 | Clear the pending state of `clr_id_o` |
| clr_id_o | output | 10 | Identifier to clear |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The acknowledge read and a change of candidate by the distributor can fall in the same cycle. The bench signals one interrupt, then drives the acknowledge read together with a different qualifying candidate. The returned word and the clear request must both name the candidate present in that cycle, and the lines must then stay low. A second pairing, completion with a candidate still offered, is judged by counting edges until the line rises again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SIGNAL = 2'd1,
        S_ACTIVE = 2'd2
    } ack_state_t;

    localparam logic [11:0] OFS_CTRL  = 12'h000;
    localparam logic [11:0] OFS_PMASK = 12'h004;
    localparam logic [11:0] OFS_ACK   = 12'h00C;
    localparam logic [11:0] OFS_EOI   = 12'h010;

    localparam int CTL_G0  = 0;
    localparam int CTL_G1  = 1;
    localparam int CTL_FIQ = 3;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ack_word,
    output logic [DATA_W-1:0] rdata,
    output logic              en_g0,
    output logic              en_g1,
    output logic              en_fiq,
    output logic [PRIO_W-1:0] pmask,
    output logic              ack_rd,
    output logic              eoi_wr
);

    logic hit_ctrl, hit_pmask, hit_ack, hit_eoi;

    always_comb begin
        hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
        hit_pmask = (addr == ADDR_W'(OFS_PMASK));
        hit_ack   = (addr == ADDR_W'(OFS_ACK));
        hit_eoi   = (addr == ADDR_W'(OFS_EOI));
        ack_rd    = sel && !wr && hit_ack;
        eoi_wr    = sel && wr && hit_eoi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_g0  <= 1'b0;
            en_g1  <= 1'b0;
            en_fiq <= 1'b0;
            pmask  <= '0;
        end else if (sel && wr) begin
            if (hit_ctrl) begin
                en_g0  <= wdata[CTL_G0];
                en_g1  <= wdata[CTL_G1];
                en_fiq <= wdata[CTL_FIQ];
            end
            if (hit_pmask) begin
                pmask <= wdata[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[CTL_G0]  = en_g0;
            rdata[CTL_G1]  = en_g1;
            rdata[CTL_FIQ] = en_fiq;
        end else if (hit_pmask) begin
            rdata[PRIO_W-1:0] = pmask;
        end else if (hit_ack) begin
            rdata = ack_word;
        end
    end

    // R1: a control write lands in the stored enables on the next edge
    p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && hit_ctrl) |=> (en_g0 == $past(wdata[CTL_G0]) &&
                                     en_fiq == $past(wdata[CTL_FIQ])));

endmodule

// File: rtl/irqc_qualify.sv
module irqc_qualify #(
    parameter int PRIO_W = 8
) (
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              cand_grp,
    input  logic              en_g0,
    input  logic              en_g1,
    input  logic              en_fiq,
    input  logic [PRIO_W-1:0] pmask,
    output logic              qual,
    output logic              route_fiq
);

    logic grp_on;
    logic prio_ok;

    always_comb begin
        grp_on    = cand_grp ? en_g1 : en_g0;
        prio_ok   = (cand_prio < pmask);
        qual      = cand_valid && grp_on && prio_ok;
        route_fiq = !cand_grp && en_fiq;
    end

endmodule

// File: rtl/irqc_ack_fsm.sv
module irqc_ack_fsm
    import irqc_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int SRC_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qual,
    input  logic              route_fiq,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [SRC_W-1:0]  cand_src,
    input  logic              ack_rd,
    input  logic              eoi_wr,
    input  logic [DATA_W-1:0] eoi_data,
    output logic [DATA_W-1:0] ack_word,
    output logic              clr_pend,
    output logic [ID_W-1:0]   clr_id,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int TAG_W = ID_W + SRC_W;
    localparam logic [ID_W-1:0] SPURIOUS = {ID_W{1'b1}};

    ack_state_t state, nxt;
    logic [ID_W-1:0]  act_id;
    logic [SRC_W-1:0] act_src;
    logic take;
    logic eoi_match;

    always_comb begin
        take      = ack_rd && (state == S_SIGNAL) && qual;
        eoi_match = eoi_wr && (eoi_data[ID_W-1:0] == act_id) &&
                    (eoi_data[TAG_W-1:ID_W] == act_src);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (qual) nxt = S_SIGNAL;
            S_SIGNAL: begin
                if (take)       nxt = S_ACTIVE;
                else if (!qual) nxt = S_IDLE;
            end
            S_ACTIVE: if (eoi_match) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // registered outputs and active record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o   <= 1'b0;
            fiq_o   <= 1'b0;
            act_id  <= '0;
            act_src <= '0;
        end else begin
            irq_o <= (nxt == S_SIGNAL) && !route_fiq;
            fiq_o <= (nxt == S_SIGNAL) && route_fiq;
            if (take) begin
                act_id  <= cand_id;
                act_src <= cand_src;
            end
        end
    end

    always_comb begin
        clr_pend = take;
        clr_id   = cand_id;
        ack_word = '0;
        if (take) ack_word[TAG_W-1:0] = {cand_src, cand_id};
        else      ack_word[ID_W-1:0]  = SPURIOUS;
    end

    // R3: the two lines are never high together
    p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && fiq_o));

    // R7: lines are low on the edge after a take
    p_quiet_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> !(irq_o || fiq_o));

    // R7: a line only rises after a qualifying cycle
    p_rise_needs_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o || fiq_o) |-> $past(qual));

    // R8: a mismatched completion leaves the interrupt active
    p_eoi_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACTIVE && eoi_wr && !eoi_match) |=> (state == S_ACTIVE));

    // R6: acknowledge while active is spurious
    p_spurious_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && state == S_ACTIVE) |-> (ack_word[ID_W-1:0] == SPURIOUS && !clr_pend));

endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              cand_grp,
    input  logic [SRC_W-1:0]  cand_src,
    output logic              clr_pend_o,
    output logic [ID_W-1:0]   clr_id_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic              en_g0, en_g1, en_fiq;
    logic [PRIO_W-1:0] pmask;
    logic              ack_rd, eoi_wr;
    logic              qual, route_fiq;
    logic [DATA_W-1:0] ack_word;

    irqc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ack_word(ack_word), .rdata(bus_rdata),
        .en_g0(en_g0), .en_g1(en_g1), .en_fiq(en_fiq), .pmask(pmask),
        .ack_rd(ack_rd), .eoi_wr(eoi_wr)
    );

    irqc_qualify #(.PRIO_W(PRIO_W)) u_qual (
        .cand_valid(cand_valid), .cand_prio(cand_prio), .cand_grp(cand_grp),
        .en_g0(en_g0), .en_g1(en_g1), .en_fiq(en_fiq), .pmask(pmask),
        .qual(qual), .route_fiq(route_fiq)
    );

    irqc_ack_fsm #(.ID_W(ID_W), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .qual(qual), .route_fiq(route_fiq),
        .cand_id(cand_id), .cand_src(cand_src),
        .ack_rd(ack_rd), .eoi_wr(eoi_wr), .eoi_data(bus_wdata),
        .ack_word(ack_word), .clr_pend(clr_pend_o), .clr_id(clr_id_o),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // R4: a raised line traces back to a priority strictly below the mask
    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o || fiq_o) |-> ($past(cand_prio) < $past(pmask)));

    // R2: a raised line traces back to an enabled group
    p_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o || fiq_o) |-> ($past(cand_grp) ? $past(en_g1) : $past(en_g0)));

endmodule

// File: tb/sim_irq_cpu_iface.sv
`timescale 1ns/1ps
module sim_irq_cpu_iface;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        cand_grp = 1'b0;
    logic [2:0]  cand_src = '0;
    logic        clr_pend_o;
    logic [9:0]  clr_id_o;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd_val;
    logic        rd_clr;
    logic [9:0]  rd_clr_id;

    always #2.5 clk = ~clk;

    irq_cpu_iface u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .cand_grp(cand_grp), .cand_src(cand_src),
        .clr_pend_o(clr_pend_o), .clr_id_o(clr_id_o),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        rd_val = bus_rdata; rd_clr = clr_pend_o; rd_clr_id = clr_id_o;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p,
                         input logic g, input logic [2:0] s);
        cand_valid = v; cand_id = id; cand_prio = p; cand_grp = g; cand_src = s;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check(!irq_o && !fiq_o, "R1 lines low after reset", {30'd0, irq_o, fiq_o}, 0);
        bus_read(12'h000); check(rd_val == 0, "R1 ctrl reset", rd_val, 0);
        bus_read(12'h004); check(rd_val == 0, "R1 mask reset", rd_val, 0);
        bus_read(12'h00C); check(rd_val == 32'h3FF, "R6 ack with nothing", rd_val, 32'h3FF);
    endtask

    task automatic t_regs;
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_read(12'h000); check(rd_val == 32'h0B, "R1 ctrl kept bits", rd_val, 32'h0B);
        bus_write(12'h004, 32'h0000_1F80);
        bus_read(12'h004); check(rd_val == 32'h80, "R1 mask 8 bits", rd_val, 32'h80);
        bus_write(12'h000, 32'h3);
    endtask

    task automatic t_take_and_complete;
        @(negedge clk);
        offer(1, 10'd42, 8'h40, 1'b1, 3'd5);
        #1 check(!irq_o, "R7 no line before edge", irq_o, 0);
        @(negedge clk);
        check(irq_o && !fiq_o, "R7 line one edge after qualify", {fiq_o, irq_o}, 1);
        bus_read(12'h00C);
        check(rd_val == ((32'd5 << 10) | 32'd42), "R5 ack word", rd_val, (32'd5 << 10) | 32'd42);
        check(rd_clr && rd_clr_id == 10'd42, "R5 clear request", {21'd0, rd_clr, rd_clr_id}, {21'd0, 1'b1, 10'd42});
        check(!irq_o && !fiq_o, "R7 low after take", irq_o, 0);
        bus_read(12'h00C);
        check(rd_val == 32'h3FF, "R6 ack while active", rd_val, 32'h3FF);
        bus_write(12'h010, 32'd42);
        idle_cycles(2);
        check(!irq_o, "R8 mismatched core number ignored", irq_o, 0);
        bus_write(12'h010, (32'd4 << 10) | 32'd43);
        idle_cycles(2);
        check(!irq_o, "R8 mismatched id ignored", irq_o, 0);
        bus_write(12'h010, (32'd5 << 10) | 32'd42);
        check(!irq_o, "R10 idle edge after completion", irq_o, 0);
        @(negedge clk);
        check(irq_o, "R10 signalled again after completion", irq_o, 1);
        bus_read(12'h00C);
        check(rd_val == ((32'd5 << 10) | 32'd42), "R5 retaken", rd_val, (32'd5 << 10) | 32'd42);
        offer(0, 0, 0, 0, 0);
        bus_write(12'h010, (32'd5 << 10) | 32'd42);
        idle_cycles(2);
        check(!irq_o, "R8 completed, nothing offered", irq_o, 0);
    endtask

    task automatic t_mask;
        bus_write(12'h004, 32'h40);
        @(negedge clk); offer(1, 10'd7, 8'h40, 1'b1, 3'd1);
        idle_cycles(2);
        check(!irq_o, "R4 equal to mask held back", irq_o, 0);
        bus_read(12'h00C);
        check(rd_val == 32'h3FF && !rd_clr, "R6 ack of masked", rd_val, 32'h3FF);
        offer(1, 10'd7, 8'h3F, 1'b1, 3'd1);
        idle_cycles(2);
        check(irq_o, "R4 below mask signalled", irq_o, 1);
        offer(0, 0, 0, 0, 0);
        idle_cycles(2);
        bus_write(12'h004, 32'h80);
    endtask

    task automatic t_groups;
        bus_write(12'h000, 32'h2);
        @(negedge clk); offer(1, 10'd20, 8'h10, 1'b0, 3'd0);
        idle_cycles(2);
        check(!irq_o && !fiq_o, "R2 group 0 disabled", irq_o, 0);
        bus_write(12'h000, 32'h1);
        offer(1, 10'd21, 8'h10, 1'b1, 3'd0);
        idle_cycles(2);
        check(!irq_o && !fiq_o, "R2 group 1 disabled", irq_o, 0);
        offer(1, 10'd20, 8'h10, 1'b0, 3'd0);
        idle_cycles(2);
        check(irq_o && !fiq_o, "R2 group 0 enabled on irq", {fiq_o, irq_o}, 1);
        offer(0, 0, 0, 0, 0);
        idle_cycles(2);
    endtask

    task automatic t_fiq;
        bus_write(12'h000, 32'hB);
        @(negedge clk); offer(1, 10'd30, 8'h10, 1'b0, 3'd2);
        idle_cycles(2);
        check(fiq_o && !irq_o, "R3 group 0 to fast line", {fiq_o, irq_o}, 2);
        offer(1, 10'd31, 8'h10, 1'b1, 3'd2);
        idle_cycles(2);
        check(irq_o && !fiq_o, "R3 group 1 stays on irq", {fiq_o, irq_o}, 1);
        offer(0, 0, 0, 0, 0);
        idle_cycles(2);
        bus_write(12'h000, 32'h3);
    endtask

    task automatic t_ctrl_off;
        @(negedge clk); offer(1, 10'd50, 8'h20, 1'b1, 3'd3);
        idle_cycles(2);
        check(irq_o, "R9 signalling before mute", irq_o, 1);
        bus_write(12'h000, 32'h0);
        @(negedge clk);
        check(!irq_o, "R9 muted by control 0", irq_o, 0);
        bus_read(12'h00C);
        check(rd_val == 32'h3FF, "R6 ack with signalling off", rd_val, 32'h3FF);
        bus_write(12'h000, 32'h3);
        @(negedge clk);
        check(irq_o, "R9 restored", irq_o, 1);
        offer(0, 0, 0, 0, 0);
        idle_cycles(2);
    endtask

    task automatic t_ack_swap;
        @(negedge clk); offer(1, 10'd10, 8'h30, 1'b1, 3'd1);
        idle_cycles(2);
        @(negedge clk);
        offer(1, 10'd11, 8'h20, 1'b1, 3'd2);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h00C;
        #1;
        rd_val = bus_rdata; rd_clr = clr_pend_o; rd_clr_id = clr_id_o;
        @(negedge clk);
        bus_sel = 1'b0;
        check(rd_val == ((32'd2 << 10) | 32'd11), "R5 ack with coincident swap", rd_val, (32'd2 << 10) | 32'd11);
        check(rd_clr && rd_clr_id == 10'd11, "R5 clear names swapped id", {21'd0, rd_clr, rd_clr_id}, {21'd0, 1'b1, 10'd11});
        check(!irq_o && !fiq_o, "R7 low after coincident take", irq_o, 0);
        offer(0, 0, 0, 0, 0);
        bus_write(12'h010, (32'd2 << 10) | 32'd11);
        idle_cycles(2);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset;
        t_regs;
        t_take_and_complete;
        t_mask;
        t_groups;
        t_fiq;
        t_ctrl_off;
        t_ack_swap;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule